// File: doc/BRIEF.md
# Bank-Aware DRAM Command Scheduler

This block takes read and write requests, each carrying a flat memory address, and turns them into the command stream of a four-bank DRAM device whose row and column addresses share one set of address pins. Every request address is cut into a bank select, a row address and a column address. A row is opened by placing the row address on the shared pins while the row strobe is raised. The column address then follows on the same pins while the column strobe is raised, which carries out the read or the write.

Requests wait in an eight-entry queue. For every bank, the scheduler records whether a row is open and which row that is. When it picks the next request, it serves the oldest queued request whose row is already open in its bank. If no such request is waiting, it serves the oldest request. A bypass counter stops a waiting request from being starved by a long stream of row hits. A parameter selects one of two page policies. With the open-page policy, a row stays open after its access, so later hits need only a column command. With the close-page policy, the bank is precharged straight after every access. Fixed, parameterised idle gaps keep precharge, activate and column commands apart.

Top module: `dram_sched`

## Requirements
- R1: The request address is split as {bank[26:25], row[24:11], column[10:0]}. An activate drives the row field onto cmd_addr, and a read or write drives the column field onto cmd_addr, zero-extended to 14 bits. cmd_bank always carries the bank field.
- R2: Each command lasts exactly one cycle and is encoded on active-high strobes. Activate is ras alone. Read is cas alone. Write is cas with we. Precharge is ras with we. No other combination ever appears, and all three strobes stay low in every other cycle.
- R3: The scheduler keeps one open-row record per bank. An activate goes only to a closed bank. A precharge goes only to an open bank. A read or write goes only to a bank that is open, and the row it accesses is the requested row.
- R4: A queued request whose row is open in its bank is served before any older request that misses. Among requests that are equally ready, the oldest is served first.
- R5: With the open-page policy, the row stays open after an access. A row hit is served with a single column command. A request to a bank that holds a different open row is served as precharge, then activate, then the column command.
- R6: With the close-page policy, the command that follows every read or write is a precharge to the same bank.
- R7: After a precharge at least T_RP (default 3) idle cycles pass before the next command. After an activate the minimum is T_RCD (default 3) idle cycles. After a read or write the minimum is T_RTP (default 2) idle cycles.
- R8: The queue holds DEPTH (default 8) waiting requests. req_ready is low exactly when eight requests are waiting, and a request is taken only in a cycle where req_valid and req_ready are both high.
- R9: After the oldest waiting request has been passed over by STARVE_MAX (default 16) consecutive picks, the next pick serves it.
- R10: While reset is active and in the first cycle after it, no command is driven and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Flat address {bank, row, column} |
| req_ready | output | 1 | Queue can take a request |
| cmd_ras | output | 1 | Row strobe |
| cmd_cas | output | 1 | Column strobe |
| cmd_we | output | 1 | Write-enable strobe |
| cmd_bank | output | 2 | Bank addressed by the command |
| cmd_addr | output | 14 | Multiplexed row or column address |

## Verification
On every cycle, the assertions check the strobe encoding and the one-idle-cycle minimum between commands. They also check that every column command lands on a bank marked open, that the queue occupancy and the bypass count stay within their limits, and that ready is low only when the queue is full. Only the bench's scenarios can show the things that depend on order and history. These are that row hits overtake older misses, that a miss to an open bank goes precharge, activate, column, and that the close-page variant precharges after each access. They also include the exact point where the bypass cap forces the oldest request through and the full-gap spacing between commands. The bench runs the open-page and close-page variants side by side and predicts each command stream from its own model of the bank states.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_CLOSE
  } seq_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_sched_queue.sv
module dram_sched_queue #(
  parameter int W     = 28,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  output logic [W-1:0]     ent [DEPTH],
  output logic [DEPTH-1:0] vld,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic [W-1:0]     mem     [DEPTH];
  logic [W-1:0]     mem_nxt [DEPTH];
  logic [DEPTH-1:0] vld_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  // Slot 0 holds the oldest entry; removal closes the gap so order equals age.
  always_comb begin
    int pos;
    mem_nxt = mem;
    vld_nxt = vld;
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(pop_idx)) begin
          if (i < DEPTH - 1) begin
            mem_nxt[i] = mem[(i + 1 < DEPTH) ? i + 1 : i];
            vld_nxt[i] = vld[(i + 1 < DEPTH) ? i + 1 : i];
          end else begin
            vld_nxt[i] = 1'b0;
          end
        end
      end
    end
    pos = int'(count) - (pop ? 1 : 0);
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == pos) begin
          mem_nxt[i] = push_data;
          vld_nxt[i] = 1'b1;
        end
      end
    end
    cnt_nxt = count + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    mem <= mem_nxt;
    if (rst) begin
      vld   <= '0;
      count <= '0;
      full  <= 1'b0;
    end else begin
      vld   <= vld_nxt;
      count <= cnt_nxt;
      full  <= (cnt_nxt == CNT_W'(DEPTH));
    end
  end

  assign ent = mem;

endmodule

// File: rtl/dram_sched_banks.sv
module dram_sched_banks #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              pre,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic [NBANK-1:0]  open,
  output logic [ROW_W-1:0]  open_row [NBANK]
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open[g]     <= 1'b0;
        open_row[g] <= '0;
      end else if (act && bank == BANK_W'(g)) begin
        open[g]     <= 1'b1;
        open_row[g] <= row;
      end else if (pre && bank == BANK_W'(g)) begin
        open[g]     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_sched_pick.sv
module dram_sched_pick #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]  vld,
  input  logic [BANK_W-1:0] q_bank [DEPTH],
  input  logic [ROW_W-1:0]  q_row  [DEPTH],
  input  logic [NBANK-1:0]  bank_open,
  input  logic [ROW_W-1:0]  bank_row [NBANK],
  input  logic              force_old,
  output logic              pick_any,
  output logic              pick_hit,
  output logic [IDX_W-1:0]  pick_idx
);

  logic [DEPTH-1:0] hit_vec;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = vld[i] && bank_open[q_bank[i]] && (bank_row[q_bank[i]] == q_row[i]);
    end
    // Lowest index among hits is the oldest hit.
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    pick_any = vld[0];
    if (|hit_vec && !force_old) begin
      pick_idx = hit_idx;
      pick_hit = 1'b1;
    end else begin
      pick_idx = '0;
      pick_hit = hit_vec[0];
    end
  end

endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 11,
  parameter int DEPTH      = 8,
  parameter int T_RP       = 3,
  parameter int T_RCD      = 3,
  parameter int T_RTP      = 2,
  parameter int STARVE_MAX = 16,
  parameter bit CLOSE_PAGE = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic                                  req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]         req_addr,
  output logic                                  req_ready,
  output logic                                  cmd_ras,
  output logic                                  cmd_cas,
  output logic                                  cmd_we,
  output logic [BANK_W-1:0]                     cmd_bank,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]  cmd_addr
);

  localparam int ADDR_W  = BANK_W + ROW_W + COL_W;
  localparam int ENT_W   = ADDR_W + 1;
  localparam int CA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NBANK   = 1 << BANK_W;
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ROW_LO  = COL_W;
  localparam int BANK_LO = COL_W + ROW_W;
  localparam int GAP_MAX = max_of3(T_RP, T_RCD, T_RTP);
  localparam int WAIT_W  = $clog2(GAP_MAX + 1);
  localparam int STV_W   = $clog2(STARVE_MAX + 1);

  // Queue
  logic [ENT_W-1:0] q_ent [DEPTH];
  logic [DEPTH-1:0] q_vld;
  logic [CNT_W-1:0] q_count;
  logic             q_full;
  logic             push, pop;
  logic [IDX_W-1:0] pick_idx;

  assign push      = req_valid && !q_full;
  assign req_ready = !q_full;

  dram_sched_queue #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(push), .push_data({req_write, req_addr}),
    .pop(pop), .pop_idx(pick_idx),
    .ent(q_ent), .vld(q_vld), .count(q_count), .full(q_full)
  );

  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_fields
    assign q_bank[g] = q_ent[g][BANK_LO +: BANK_W];
    assign q_row[g]  = q_ent[g][ROW_LO +: ROW_W];
  end

  // Bank state
  seq_state_e       state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [ENT_W-1:0] cur_q;
  logic [STV_W-1:0] starve_q;
  logic             do_pre, do_act, do_col;
  logic [NBANK-1:0] bank_open;
  logic [ROW_W-1:0] bank_row [NBANK];

  wire [BANK_W-1:0] cur_bank = cur_q[BANK_LO +: BANK_W];
  wire [ROW_W-1:0]  cur_row  = cur_q[ROW_LO +: ROW_W];
  wire [COL_W-1:0]  cur_col  = cur_q[COL_W-1:0];
  wire              cur_wr   = cur_q[ADDR_W];

  assign do_pre = (state_q == ST_PRE || state_q == ST_CLOSE) && wait_q == '0;
  assign do_act = (state_q == ST_ACT) && wait_q == '0;
  assign do_col = (state_q == ST_COL) && wait_q == '0;

  dram_sched_banks #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst(rst),
    .act(do_act), .pre(do_pre), .bank(cur_bank), .row(cur_row),
    .open(bank_open), .open_row(bank_row)
  );

  // Selection
  logic pick_any, pick_hit, force_old;
  assign force_old = (starve_q >= STV_W'(STARVE_MAX));

  dram_sched_pick #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_pick (
    .vld(q_vld), .q_bank(q_bank), .q_row(q_row),
    .bank_open(bank_open), .bank_row(bank_row),
    .force_old(force_old),
    .pick_any(pick_any), .pick_hit(pick_hit), .pick_idx(pick_idx)
  );

  assign pop = (state_q == ST_IDLE) && pick_any;

  // Command sequencer
  logic              ras_q, cas_q, we_q;
  logic [BANK_W-1:0] bank_q;
  logic [CA_W-1:0]   addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wait_q   <= '0;
      cur_q    <= '0;
      starve_q <= '0;
      ras_q    <= 1'b0;
      cas_q    <= 1'b0;
      we_q     <= 1'b0;
      bank_q   <= '0;
      addr_q   <= '0;
    end else begin
      ras_q <= 1'b0;
      cas_q <= 1'b0;
      we_q  <= 1'b0;
      if (wait_q != '0) wait_q <= wait_q - WAIT_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (pick_any) begin
            cur_q    <= q_ent[pick_idx];
            starve_q <= (pick_idx == '0) ? '0 : starve_q + STV_W'(1);
            if (pick_hit)
              state_q <= ST_COL;
            else if (bank_open[q_bank[pick_idx]])
              state_q <= ST_PRE;
            else
              state_q <= ST_ACT;
          end
        end
        ST_PRE, ST_CLOSE: begin
          if (do_pre) begin
            ras_q   <= 1'b1;
            we_q    <= 1'b1;
            bank_q  <= cur_bank;
            addr_q  <= '0;
            wait_q  <= WAIT_W'(T_RP);
            state_q <= (state_q == ST_PRE) ? ST_ACT : ST_IDLE;
          end
        end
        ST_ACT: begin
          if (do_act) begin
            ras_q   <= 1'b1;
            bank_q  <= cur_bank;
            addr_q  <= CA_W'(cur_row);
            wait_q  <= WAIT_W'(T_RCD);
            state_q <= ST_COL;
          end
        end
        ST_COL: begin
          if (do_col) begin
            cas_q   <= 1'b1;
            we_q    <= cur_wr;
            bank_q  <= cur_bank;
            addr_q  <= CA_W'(cur_col);
            wait_q  <= WAIT_W'(T_RTP);
            state_q <= CLOSE_PAGE ? ST_CLOSE : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ras  = ras_q;
  assign cmd_cas  = cas_q;
  assign cmd_we   = we_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;

endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
  parameter int NBANK      = 4,
  parameter int BANK_W     = 2,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 4,
  parameter int STV_W      = 5,
  parameter int STARVE_MAX = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              cmd_ras,
  input logic              cmd_cas,
  input logic              cmd_we,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [NBANK-1:0]  bank_open,
  input logic [CNT_W-1:0]  q_count,
  input logic [STV_W-1:0]  starve_q
);

  // R2: row and column strobes never together
  a_r2_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ras && cmd_cas));

  // R2: write-enable only accompanies a strobe
  a_r2_we_paired: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> (cmd_ras || cmd_cas));

  // R7: every command is followed by at least one idle cycle
  a_r7_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_ras || cmd_cas) |=> !(cmd_ras || cmd_cas));

  // R3: a column command addresses an open bank
  a_r3_col_open: assert property (@(posedge clk) disable iff (rst)
    cmd_cas |-> bank_open[cmd_bank]);

  // R8: occupancy bounded, ready low only when full
  a_r8_depth: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  a_r8_ready_full: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (q_count == CNT_W'(DEPTH)));

  // R9: bypass count never passes the cap
  a_r9_cap: assert property (@(posedge clk) disable iff (rst)
    starve_q <= STV_W'(STARVE_MAX));

  // R10: quiet right after reset
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cmd_ras && !cmd_cas && req_ready));

endmodule

bind dram_sched dram_sched_chk #(
  .NBANK(NBANK), .BANK_W(BANK_W), .DEPTH(DEPTH),
  .CNT_W(CNT_W), .STV_W(STV_W), .STARVE_MAX(STARVE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we), .cmd_bank(cmd_bank),
  .bank_open(bank_open), .q_count(q_count), .starve_q(starve_q)
);

// File: tb/dram_sched_test.sv
module dram_sched_test;

  localparam int AW = 27;
  localparam int K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          rv [2];
  logic          rw [2];
  logic [AW-1:0] ra [2];
  logic          rdy [2];
  logic          ras [2];
  logic          cas [2];
  logic          we  [2];
  logic [1:0]    cbk [2];
  logic [13:0]   cad [2];

  dram_sched #(.CLOSE_PAGE(1'b0)) uut (
    .clk(clk), .rst(rst), .req_valid(rv[0]), .req_write(rw[0]), .req_addr(ra[0]),
    .req_ready(rdy[0]), .cmd_ras(ras[0]), .cmd_cas(cas[0]), .cmd_we(we[0]),
    .cmd_bank(cbk[0]), .cmd_addr(cad[0]));

  dram_sched #(.CLOSE_PAGE(1'b1)) uut_cp (
    .clk(clk), .rst(rst), .req_valid(rv[1]), .req_write(rw[1]), .req_addr(ra[1]),
    .req_ready(rdy[1]), .cmd_ras(ras[1]), .cmd_cas(cas[1]), .cmd_we(we[1]),
    .cmd_bank(cbk[1]), .cmd_addr(cad[1]));

  int errors = 0, checks = 0, cyc = 0;
  bit m_open [2][4];
  int m_row  [2][4];
  int idle [2], last_k [2], acc [2], cols [2], ncmd [2];
  bit have_last [2], pend [2], saw_full [2];
  int pend_bank [2];
  int lk [2][128], lb [2][128], la [2][128];
  int cb_log [2][64], cr_log [2][64], cc_log [2][64];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gap_of(input int k);
    if (k == K_PRE) return 3;
    if (k == K_ACT) return 3;
    return 2;
  endfunction

  task automatic mon(input int i);
    int k, b, d;
    if (ras[i] || cas[i]) begin
      b = int'(cbk[i]);
      if (ras[i] && !cas[i] && !we[i]) k = K_ACT;
      else if (cas[i] && !ras[i] && !we[i]) k = K_RD;
      else if (cas[i] && !ras[i] && we[i]) k = K_WR;
      else if (ras[i] && !cas[i] && we[i]) k = K_PRE;
      else k = 0;
      chk(k != 0, "R2", "strobe combination", k, 1);
      if (have_last[i]) chk(idle[i] >= gap_of(last_k[i]), "R7", "idle cycles after command", idle[i], gap_of(last_k[i]));
      if (pend[i]) chk(k == K_PRE && b == pend_bank[i], "R6", "precharge after access (bank)", b, pend_bank[i]);
      if (k == K_ACT) begin
        chk(!m_open[i][b], "R3", "activate to open bank", b, -1);
        m_open[i][b] = 1'b1;
        m_row[i][b]  = int'(cad[i]);
      end else if (k == K_PRE) begin
        chk(m_open[i][b], "R3", "precharge to closed bank", b, -1);
        m_open[i][b] = 1'b0;
      end else if (k != 0) begin
        chk(m_open[i][b], "R3", "column to closed bank", b, -1);
        if (cols[i] < 64) begin
          cb_log[i][cols[i]] = b;
          cr_log[i][cols[i]] = m_row[i][b];
          cc_log[i][cols[i]] = int'(cad[i]);
        end
        cols[i]++;
      end
      pend[i]      = (i == 1) && (k == K_RD || k == K_WR);
      pend_bank[i] = b;
      if (ncmd[i] < 128) begin
        lk[i][ncmd[i]] = k; lb[i][ncmd[i]] = b; la[i][ncmd[i]] = int'(cad[i]);
      end
      ncmd[i]++;
      idle[i] = 0; last_k[i] = k; have_last[i] = 1'b1;
    end else begin
      idle[i]++;
    end
    d = acc[i] - cols[i];
    if (!rdy[i]) begin
      saw_full[i] = 1'b1;
      chk(d >= 8, "R8", "ready low with fewer than 8 waiting", d, 8);
    end else begin
      chk(d <= 8, "R8", "ready high with queue full", d, 8);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    mon(0);
    mon(1);
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) if (!rst && rv[i] && rdy[i]) acc[i]++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // Called right after a negedge; leaves valid high, returns after the next negedge.
  task automatic push(input int i, input bit w, input int b, input int r, input int c);
    while (!rdy[i]) @(negedge clk);
    rv[i] = 1'b1;
    rw[i] = w;
    ra[i] = {b[1:0], r[13:0], c[10:0]};   // R1 field layout
    @(negedge clk);
  endtask

  task automatic wait_cols(input int i, input int target);
    int t;
    t = 0;
    while (cols[i] < target && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (12) @(negedge clk);
    chk(cols[i] == target, "R4", "column commands after drain", cols[i], target);
  endtask

  task automatic exp_cmd(input int i, input int j, input int k, input int b, input int a, input string req);
    chk(lk[i][j] == k, req, $sformatf("inst%0d cmd %0d kind", i, j), lk[i][j], k);
    chk(lb[i][j] == b, req, $sformatf("inst%0d cmd %0d bank", i, j), lb[i][j], b);
    if (k != K_PRE) chk(la[i][j] == a, req, $sformatf("inst%0d cmd %0d addr", i, j), la[i][j], a);
  endtask

  task automatic scen_a(input int i);
    @(negedge clk);
    push(i, 1'b0, 0, 5, 1);
    push(i, 1'b1, 0, 7, 2);
    push(i, 1'b0, 0, 5, 3);
    push(i, 1'b0, 1, 9, 4);
    rv[i] = 1'b0;
  endtask

  task automatic scen_c(input int i);
    @(negedge clk);
    for (int b = 0; b < 4; b++) push(i, b[0], b, 16383 - b, 2047 - b);
    rv[i] = 1'b0;
  endtask

  initial begin
    int base;
    for (int i = 0; i < 2; i++) begin
      rv[i] = 1'b0; rw[i] = 1'b0; ra[i] = '0;
      idle[i] = 0; last_k[i] = 0; acc[i] = 0; cols[i] = 0; ncmd[i] = 0;
      have_last[i] = 1'b0; pend[i] = 1'b0; pend_bank[i] = 0; saw_full[i] = 1'b0;
      for (int b = 0; b < 4; b++) begin m_open[i][b] = 1'b0; m_row[i][b] = 0; end
    end
    repeat (4) @(negedge clk);
    // R10: during reset
    chk(rdy[0] && rdy[1], "R10", "ready in reset", int'(rdy[0]), 1);
    chk(!ras[0] && !cas[0] && !ras[1] && !cas[1], "R10", "strobes in reset", int'(ras[0]), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy[0] && rdy[1], "R10", "ready after reset", int'(rdy[1]), 1);
    chk(ncmd[0] == 0 && ncmd[1] == 0, "R10", "no command after reset", ncmd[0] + ncmd[1], 0);

    // Scenario A: hit overtakes older miss (R4, R5), close-page sequence (R6), R1 fields
    fork
      scen_a(0);
      scen_a(1);
    join
    wait_cols(0, 4);
    wait_cols(1, 4);
    chk(ncmd[0] == 8, "R5", "open-page command count", ncmd[0], 8);
    exp_cmd(0, 0, K_ACT, 0, 5, "R1");
    exp_cmd(0, 1, K_RD,  0, 1, "R1");
    exp_cmd(0, 2, K_RD,  0, 3, "R4");
    exp_cmd(0, 3, K_PRE, 0, 0, "R5");
    exp_cmd(0, 4, K_ACT, 0, 7, "R5");
    exp_cmd(0, 5, K_WR,  0, 2, "R2");
    exp_cmd(0, 6, K_ACT, 1, 9, "R4");
    exp_cmd(0, 7, K_RD,  1, 4, "R4");
    chk(ncmd[1] == 12, "R6", "close-page command count", ncmd[1], 12);
    exp_cmd(1, 0,  K_ACT, 0, 5, "R6");
    exp_cmd(1, 1,  K_RD,  0, 1, "R6");
    exp_cmd(1, 2,  K_PRE, 0, 0, "R6");
    exp_cmd(1, 3,  K_ACT, 0, 7, "R6");
    exp_cmd(1, 4,  K_WR,  0, 2, "R6");
    exp_cmd(1, 5,  K_PRE, 0, 0, "R6");
    exp_cmd(1, 6,  K_ACT, 0, 5, "R6");
    exp_cmd(1, 7,  K_RD,  0, 3, "R6");
    exp_cmd(1, 8,  K_PRE, 0, 0, "R6");
    exp_cmd(1, 9,  K_ACT, 1, 9, "R6");
    exp_cmd(1, 10, K_RD,  1, 4, "R6");
    exp_cmd(1, 11, K_PRE, 1, 0, "R6");

    // Scenario B: stream of hits against one waiting miss, bypass cap (R9), full queue (R8)
    base = cols[0];
    @(negedge clk);
    push(0, 1'b0, 0, 1, 0);
    push(0, 1'b0, 0, 2, 2047);
    for (int h = 1; h <= 30; h++) push(0, h[0], 0, 1, h);
    rv[0] = 1'b0;
    wait_cols(0, base + 32);
    chk(saw_full[0], "R8", "ready observed low under flood", int'(saw_full[0]), 1);
    for (int j = 0; j < 32; j++) begin
      int ec, er;
      if (j == 0) begin ec = 0; er = 1; end
      else if (j <= 16) begin ec = j; er = 1; end
      else if (j == 17) begin ec = 2047; er = 2; end
      else begin ec = j - 1; er = 1; end
      chk(cc_log[0][base + j] == ec, "R9", $sformatf("column order slot %0d", j), cc_log[0][base + j], ec);
      chk(cr_log[0][base + j] == er, "R5", $sformatf("row used at slot %0d", j), cr_log[0][base + j], er);
    end

    // Scenario C: extreme field values on every bank, both policies (R1, R4)
    base = cols[0];
    fork
      scen_c(0);
      scen_c(1);
    join
    wait_cols(0, base + 4);
    wait_cols(1, 8);
    for (int b = 0; b < 4; b++) begin
      chk(cb_log[0][base + b] == b, "R1", "bank field", cb_log[0][base + b], b);
      chk(cr_log[0][base + b] == 16383 - b, "R1", "row field", cr_log[0][base + b], 16383 - b);
      chk(cc_log[0][base + b] == 2047 - b, "R1", "column field", cc_log[0][base + b], 2047 - b);
      chk(cb_log[1][4 + b] == b, "R1", "bank field close-page", cb_log[1][4 + b], b);
      chk(cr_log[1][4 + b] == 16383 - b, "R1", "row field close-page", cr_log[1][4 + b], 16383 - b);
      chk(cc_log[1][4 + b] == 2047 - b, "R1", "column field close-page", cc_log[1][4 + b], 2047 - b);
    end
    for (int b = 0; b < 4; b++)
      chk(!m_open[1][b], "R6", "bank left closed", int'(m_open[1][b]), 0);

    summary();
    $finish;
  end

endmodule